// File: doc/BRIEF.md
# Delta-Sigma Bitstream Health Monitor

This block sits on the receive side of an isolated one-bit delta-sigma link. It watches the stream of data bits, taken on the rising edge of the clock that also drives the remote modulator, and sorts the link into one of four conditions:

- normal modulation;
- positive overrange;
- negative overrange;
- a failed source.

A modulator driven past full scale still stays alive. It emits a long run of one level and breaks that run with a single bit of the other level once every 128 clocks. A modulator that has lost its supply holds its output at one level and the marker bit never comes. The monitor tracks how long the current run of identical bits is. It uses that length, and what ends the run, to tell the two cases apart.

A decimation filter and a supervisor are meant to use the outputs side by side. The two-bit status code tells the filter whether its result is meaningful. The sticky fault flag keeps a record of any failed-source event until software clears it.

Top module: `bitstream_health_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the outputs are `status_code` = 2'b00, `status_vld` = 0 and `fault_sticky` = 0.
- R2: `status_vld` stays low until 160 samples with `smp_vld` high have been taken since reset. It rises after the clock edge of the 160th such sample and then stays high until reset.
- R3: A cycle with `smp_vld` low is not a sample. It does not count toward R2 and does not affect any run, whatever `smp_bit` holds.
- R4: A run of at least 127 ones that is ended by a 0 sets `status_code` to 2'b01 (positive overrange) after the edge of that 0.
- R5: A run of at least 127 zeros that is ended by a 1 sets `status_code` to 2'b10 (negative overrange) after the edge of that 1.
- R6: The 161st consecutive identical sample sets `status_code` to 2'b11 (failed source) and sets `fault_sticky`. A run of exactly 160 does neither.
- R7: `fault_sticky` falls only on a cycle with `clr_fault` high or on reset. While the status remains failed source, the set wins over `clr_fault`.
- R8: From an overrange status, the code returns to 2'b00 after the 128th consecutive sample that did not bring any run to a length of 127.
- R9: A run of 126 identical bits that is ended by the opposite bit leaves a normal status at 2'b00.
- R10: When a failed-source run is ended by the opposite bit, the code becomes overrange with the run's polarity: 2'b01 for ones, 2'b10 for zeros.
- R11: `status_code` does not change on cycles with `smp_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, the same clock that drives the modulator |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | High on cycles where `smp_bit` is a new sample |
| smp_bit | input | 1 | Data bit from the modulator, taken on the rising edge |
| clr_fault | input | 1 | Clears the sticky fault flag |
| status_code | output | 2 | 00 normal, 01 positive overrange, 10 negative overrange, 11 failed source |
| status_vld | output | 1 | High once the warm-up sample count has been reached |
| fault_sticky | output | 1 | Latched failed-source indication |

## Verification
The hardest condition to reach from the ports is a failed source whose fault is cleared while the run is still going. That needs a run of more than 160 identical samples, then a `clr_fault` pulse during idle cycles, and only after that the bit that ends the run.

The directed tasks build exact run lengths around each threshold:
- 126, 127, 160 and 161 identical samples;
- a run split by idle cycles in which `smp_bit` toggles, which shows that idle cycles neither break nor extend it;
- a return to normal timed to the exact sample at which the quiet window completes.

// File: rtl/bsmon_pkg.sv
package bsmon_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'b00,
        ST_POS    = 2'b01,
        ST_NEG    = 2'b10,
        ST_DEAD   = 2'b11
    } bs_status_e;

    // Per-sample events produced by the run tracker
    typedef struct packed {
        logic valid;       // this cycle carries a sample
        logic ended_long;  // a run of at least MARK-1 bits was just broken
        logic pol;         // level of the run that is current before this sample
        logic saturated;   // run length reaches MARK-1 with this sample
        logic dead;        // run length exceeds the dead limit
    } run_ev_t;

    function automatic bs_status_e overrange_code(input logic level);
        return level ? ST_POS : ST_NEG;
    endfunction

endpackage

// File: rtl/bsmon_run_tracker.sv
module bsmon_run_tracker
    import bsmon_pkg::*;
#(
    parameter int MARK_PERIOD = 128,
    parameter int DEAD_LIMIT  = 160
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    smp_vld,
    input  logic    smp_bit,
    output run_ev_t ev
);
    localparam int LEN_W = $clog2(DEAD_LIMIT + 2);
    localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(DEAD_LIMIT + 1);
    localparam logic [LEN_W-1:0] SAT_LEN  = LEN_W'(MARK_PERIOD - 1);
    localparam logic [LEN_W-1:0] DEAD_LEN = LEN_W'(DEAD_LIMIT);

    logic             run_val;
    logic [LEN_W-1:0] run_len;
    logic [LEN_W-1:0] len_nxt;
    logic             same;

    always_comb begin
        same = (smp_bit == run_val);
        if (same) begin
            len_nxt = (run_len == LEN_MAX) ? LEN_MAX : run_len + 1'b1;
        end else begin
            len_nxt = LEN_W'(1);
        end
        ev.valid      = smp_vld;
        ev.pol        = run_val;
        ev.ended_long = smp_vld && !same && (run_len >= SAT_LEN);
        ev.saturated  = smp_vld && (len_nxt >= SAT_LEN);
        ev.dead       = smp_vld ? (len_nxt > DEAD_LEN) : (run_len > DEAD_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_val <= 1'b0;
            run_len <= '0;
        end else if (smp_vld) begin
            run_val <= smp_bit;
            run_len <= len_nxt;
        end
    end

    // R6: the saturating run counter never passes its cap
    assert_len_cap_R6: assert property (@(posedge clk) disable iff (rst)
        run_len <= LEN_MAX);

    // R3: without a sample the run is untouched
    assert_idle_run_R3: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(run_len) && $stable(run_val));

endmodule

// File: rtl/bsmon_warmup.sv
module bsmon_warmup #(
    parameter int WARMUP = 160
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_vld,
    output logic ready
);
    localparam int CW = $clog2(WARMUP + 1);
    localparam logic [CW-1:0] CMAX = CW'(WARMUP);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (smp_vld && cnt != CMAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (cnt == CMAX);

    // R2: once valid, the status stays valid until reset
    assert_ready_hold_R2: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

endmodule

// File: rtl/bsmon_classifier.sv
module bsmon_classifier
    import bsmon_pkg::*;
#(
    parameter int MARK_PERIOD = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  run_ev_t    ev,
    input  logic       clr_fault,
    output bs_status_e status,
    output logic       fault
);
    localparam int QW = $clog2(MARK_PERIOD + 1);
    localparam logic [QW-1:0] QMAX = QW'(MARK_PERIOD);

    logic [QW-1:0] quiet, quiet_nxt;
    bs_status_e    st_nxt;
    logic          fault_nxt;

    always_comb begin
        quiet_nxt = quiet;
        if (ev.valid) begin
            if (ev.saturated) begin
                quiet_nxt = '0;
            end else if (quiet != QMAX) begin
                quiet_nxt = quiet + 1'b1;
            end
        end

        st_nxt = status;
        if (ev.dead) begin
            st_nxt = ST_DEAD;
        end else if (ev.ended_long) begin
            st_nxt = overrange_code(ev.pol);
        end else if (ev.valid && quiet_nxt == QMAX && status != ST_DEAD) begin
            st_nxt = ST_NORMAL;
        end

        if (st_nxt == ST_DEAD) begin
            fault_nxt = 1'b1;
        end else if (clr_fault) begin
            fault_nxt = 1'b0;
        end else begin
            fault_nxt = fault;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet  <= '0;
            status <= ST_NORMAL;
            fault  <= 1'b0;
        end else begin
            quiet  <= quiet_nxt;
            status <= st_nxt;
            fault  <= fault_nxt;
        end
    end

    // R7: the latched fault only drops after a clear request
    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(fault) |-> $past(clr_fault));

    // R6: a failed-source status is always accompanied by the latched fault
    assert_dead_latched_R6: assert property (@(posedge clk) disable iff (rst)
        (status == ST_DEAD) |-> fault);

    // R11: the status holds across cycles without a sample
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !ev.valid |=> $stable(status));

endmodule

// File: rtl/bitstream_health_monitor.sv
module bitstream_health_monitor
    import bsmon_pkg::*;
#(
    parameter int MARK_PERIOD = 128,
    parameter int DEAD_LIMIT  = 160,
    parameter int WARMUP      = 160
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       smp_vld,
    input  logic       smp_bit,
    input  logic       clr_fault,
    output logic [1:0] status_code,
    output logic       status_vld,
    output logic       fault_sticky
);
    run_ev_t    ev;
    bs_status_e status;

    bsmon_run_tracker #(
        .MARK_PERIOD (MARK_PERIOD),
        .DEAD_LIMIT  (DEAD_LIMIT)
    ) u_runs (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_vld),
        .smp_bit (smp_bit),
        .ev      (ev)
    );

    bsmon_warmup #(
        .WARMUP (WARMUP)
    ) u_warm (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_vld),
        .ready   (status_vld)
    );

    bsmon_classifier #(
        .MARK_PERIOD (MARK_PERIOD)
    ) u_cls (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .clr_fault (clr_fault),
        .status    (status),
        .fault     (fault_sticky)
    );

    assign status_code = status;

endmodule

// File: tb/tb_bitstream_health_monitor.sv
`timescale 1ns/1ps
module tb_bitstream_health_monitor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_vld = 1'b0;
    logic       smp_bit = 1'b0;
    logic       clr_fault = 1'b0;
    logic [1:0] status_code;
    logic       status_vld;
    logic       fault_sticky;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bitstream_health_monitor dut (
        .clk          (clk),
        .rst          (rst),
        .smp_vld      (smp_vld),
        .smp_bit      (smp_bit),
        .clr_fault    (clr_fault),
        .status_code  (status_code),
        .status_vld   (status_vld),
        .fault_sticky (fault_sticky)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic b);
        @(negedge clk);
        smp_vld = 1'b1;
        smp_bit = b;
        @(posedge clk);
        #1;
        smp_vld = 1'b0;
    endtask

    task automatic send_run(input int n, input logic b);
        for (int i = 0; i < n; i++) send(b);
    endtask

    task automatic send_alt(input int n, input logic first);
        for (int i = 0; i < n; i++) send(first ^ logic'(i[0]));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_vld = 1'b0;
            smp_bit = ~smp_bit;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_clear;
        @(negedge clk);
        clr_fault = 1'b1;
        @(posedge clk);
        #1;
        clr_fault = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1 status in reset", status_code, 0);
        check("R1 valid in reset", status_vld, 0);
        check("R1 fault in reset", fault_sticky, 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 status after reset", status_code, 0);
        check("R1 valid after reset", status_vld, 0);
    endtask

    task automatic test_warmup;
        send_alt(159, 1'b1);
        check("R2 valid low at 159", status_vld, 0);
        idle(20);
        check("R3 idle not counted", status_vld, 0);
        send(1'b0);
        check("R2 valid at 160", status_vld, 1);
        check("R2 normal on toggling", status_code, 0);
    endtask

    task automatic test_positive;
        send(1'b0);
        send_run(127, 1'b1);
        check("R4 unended run", status_code, 0);
        send(1'b0);
        check("R4 positive overrange", status_code, 1);
        send_run(127, 1'b1);
        send(1'b0);
        check("R4 repeated frame", status_code, 1);
        send_alt(126, 1'b1);
        check("R8 window not complete", status_code, 1);
        send(1'b1);
        check("R8 back to normal", status_code, 0);
    endtask

    task automatic test_negative;
        send_run(127, 1'b0);
        send(1'b1);
        check("R5 negative overrange", status_code, 2);
        send_alt(127, 1'b0);
        check("R8 normal after negative", status_code, 0);
    endtask

    task automatic test_idle_split;
        send(1'b1);
        send_run(60, 1'b0);
        idle(10);
        check("R11 idle keeps status", status_code, 0);
        send_run(67, 1'b0);
        check("R3 split run not ended", status_code, 0);
        send(1'b1);
        check("R3 idle did not break run", status_code, 2);
        idle(5);
        check("R11 overrange held idle", status_code, 2);
        send_alt(127, 1'b0);
        check("R8 normal again", status_code, 0);
    endtask

    task automatic test_boundary;
        send(1'b0);
        send_run(126, 1'b1);
        send(1'b0);
        check("R9 run of 126 stays normal", status_code, 0);
    endtask

    task automatic test_dead;
        send(1'b0);
        send_run(160, 1'b1);
        check("R6 run of 160 not failed", status_code, 0);
        check("R6 no fault at 160", fault_sticky, 0);
        send(1'b1);
        check("R6 failed source", status_code, 3);
        check("R6 fault set", fault_sticky, 1);
        pulse_clear();
        check("R7 set wins over clear", fault_sticky, 1);
        check("R11 failed held idle", status_code, 3);
        send(1'b0);
        check("R10 failed run ended positive", status_code, 1);
        check("R7 fault sticky", fault_sticky, 1);
        pulse_clear();
        check("R7 fault cleared", fault_sticky, 0);
        send_run(160, 1'b0);
        check("R6 failed on zeros", status_code, 3);
        check("R6 fault on zeros", fault_sticky, 1);
        send(1'b1);
        check("R10 failed run ended negative", status_code, 2);
    endtask

    initial begin
        fork
            begin
                do_reset();
                test_warmup();
                test_positive();
                test_negative();
                test_idle_split();
                test_boundary();
                test_dead();
                do_reset();
            end
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule